// File: doc/BRIEF.md
# Frame-Synchronized Display Start Address

This block is the slice of a display controller's register file that holds where in the frame buffer the visible picture begins. Software programs it through a small indexed port: an 8-bit index selects a byte-wide register and an 8-bit data bus carries the value written. Reads are combinational on the same index. The block presents one 32-bit start address to the scan-out engine.

A mode bit in a control register picks one of two address formats.

- **Legacy format.** A 16-bit offset is built from a high byte and a low byte. It follows those registers as soon as they are written.
- **Extended format.** A 32-bit, word-aligned byte address is built from four registers. The shadow values never reach the output directly. Software writes all four registers and then sets a commit bit. On the next rising edge of vertical sync, the whole address moves into the active register at once, and the hardware clears the commit bit. Software can poll the commit bit to learn that the new frame origin has taken effect.

The vertical sync input is asynchronous to the register clock. It passes through a configurable synchronizer before its rising edge is detected.

Top module: `disp_start_addr`

## Requirements
- R1: After reset, every shadow register reads 0, the commit status is 0 and `start_addr` is 0.
- R2: A write with `cfg_wr` high stores `cfg_wdata` into the register selected by `cfg_idx`. The indices are: high byte 0x0C, low byte 0x0D, extended byte 0x20, extended-high byte 0x21, control 0x30. `cfg_rdata` returns the stored value of the selected register, and returns 0 for any other index.
- R3: With control bit 0 clear (legacy), `start_addr` equals {16'h0000, high, low} from the cycle after the write.
- R4: With control bit 0 set (extended), `start_addr` is the active copy of {ext-high[7:0], ext[5:0], high[7:0], low[7:0], 2'b00}.
- R5: In extended mode, writes to the four address registers leave `start_addr` unchanged until a transfer.
- R6: Writing index 0x20 with data bit 7 set arms the commit flag. Writing it with bit 7 clear does not clear the flag. Reading index 0x20 returns the live flag in bit 7, and `commit_pending` mirrors it.
- R7: A transfer happens on the first clock edge after `vsync_in`'s rising edge has passed the SYNC_STAGES synchronizer, and only while the flag is armed. A sync edge with the flag clear leaves `start_addr` unchanged.
- R8: A transfer clears the commit flag. A vsync level held high causes no second transfer, even if software re-arms the flag while it is high.
- R9: If software arms the flag in the same cycle as a transfer, the set wins. The flag stays armed, and the next sync edge performs another transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the indexed port |
| cfg_idx | input | 8 | Register index |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for `cfg_idx` |
| vsync_in | input | 1 | Asynchronous vertical sync |
| start_addr | output | 32 | Start address to scan-out |
| commit_pending | output | 1 | Commit flag status |

## Verification
The bench builds the block with its default values: SYNC_STAGES of 2, an 8-bit byte width and the default register indices. With two synchronizer stages, the transfer lands on the third clock edge after vsync rises. That fixed edge lets the bench place a software arm write in exactly the transfer cycle to exercise the set-over-clear race. The fixed indices let it probe an unused index, and holding vsync high shows that one pulse produces only one transfer.

// File: rtl/dsa_pkg.sv
package dsa_pkg;
   localparam int BYTE_W = 8;
   localparam int ADDR_W = 32;

   typedef struct packed {
      logic [BYTE_W-1:0] hi;
      logic [BYTE_W-1:0] lo;
      logic [BYTE_W-1:0] ext;
      logic [BYTE_W-1:0] exthi;
      logic [BYTE_W-1:0] ctrl;
   } dsa_shadow_t;

   function automatic logic [ADDR_W-1:0] dsa_ext_addr(dsa_shadow_t s);
      return {s.exthi, s.ext[5:0], s.hi, s.lo, 2'b00};
   endfunction

   function automatic logic [ADDR_W-1:0] dsa_legacy_addr(dsa_shadow_t s);
      return {{(ADDR_W-2*BYTE_W){1'b0}}, s.hi, s.lo};
   endfunction
endpackage

// File: rtl/dsa_sync.sv
module dsa_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   logic [SYNC_STAGES-1:0] chain_q;
   logic                   last_q;

   generate
      if (SYNC_STAGES < 2) begin : g_bad
         $error("dsa_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[SYNC_STAGES-2:0], async_in};
         last_q  <= chain_q[SYNC_STAGES-1];
      end
   end

   assign rise = chain_q[SYNC_STAGES-1] & ~last_q;

   // R8
   rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/dsa_regfile.sv
module dsa_regfile
   import dsa_pkg::*;
#(
   parameter logic [7:0] IDX_HI    = 8'h0C,
   parameter logic [7:0] IDX_LO    = 8'h0D,
   parameter logic [7:0] IDX_EXT   = 8'h20,
   parameter logic [7:0] IDX_EXTHI = 8'h21,
   parameter logic [7:0] IDX_CTRL  = 8'h30,
   parameter int         ARM_BIT   = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [7:0]        idx,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              xfer,
   output dsa_shadow_t       shadow,
   output logic              commit,
   output logic [BYTE_W-1:0] rdata
);
   dsa_shadow_t sh_q;
   logic        commit_q;
   logic        arm_set;

   assign arm_set = wr && (idx == IDX_EXT) && wdata[ARM_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q     <= '0;
         commit_q <= 1'b0;
      end else begin
         if (wr) begin
            unique case (idx)
               IDX_HI:    sh_q.hi    <= wdata;
               IDX_LO:    sh_q.lo    <= wdata;
               IDX_EXT:   sh_q.ext   <= wdata;
               IDX_EXTHI: sh_q.exthi <= wdata;
               IDX_CTRL:  sh_q.ctrl  <= wdata;
               default:   ;
            endcase
         end
         if (arm_set)
            commit_q <= 1'b1;
         else if (xfer)
            commit_q <= 1'b0;
      end
   end

   always_comb begin
      unique case (idx)
         IDX_HI:    rdata = sh_q.hi;
         IDX_LO:    rdata = sh_q.lo;
         IDX_EXT: begin
            rdata          = sh_q.ext;
            rdata[ARM_BIT] = commit_q;
         end
         IDX_EXTHI: rdata = sh_q.exthi;
         IDX_CTRL:  rdata = sh_q.ctrl;
         default:   rdata = '0;
      endcase
   end

   assign shadow = sh_q;
   assign commit = commit_q;

   // R6
   arm_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arm_set |=> commit_q);
   // R8
   xfer_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && !arm_set) |=> !commit_q);
   // R6
   only_xfer_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(commit_q) |-> $past(xfer));
endmodule

// File: rtl/dsa_active.sv
module dsa_active
   import dsa_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer,
   input  dsa_shadow_t       shadow,
   output logic [ADDR_W-1:0] active
);
   logic [ADDR_W-1:0] act_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         act_q <= '0;
      else if (xfer)
         act_q <= dsa_ext_addr(shadow);
   end

   assign active = act_q;

   // R5
   hold_no_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer |=> $stable(act_q));
endmodule

// File: rtl/disp_start_addr.sv
module disp_start_addr
   import dsa_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter int         MODE_BIT    = 0,
   parameter logic [7:0] IDX_HI      = 8'h0C,
   parameter logic [7:0] IDX_LO      = 8'h0D,
   parameter logic [7:0] IDX_EXT     = 8'h20,
   parameter logic [7:0] IDX_EXTHI   = 8'h21,
   parameter logic [7:0] IDX_CTRL    = 8'h30
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_wr,
   input  logic [7:0]  cfg_idx,
   input  logic [7:0]  cfg_wdata,
   output logic [7:0]  cfg_rdata,
   input  logic        vsync_in,
   output logic [31:0] start_addr,
   output logic        commit_pending
);
   localparam int ARM_BIT = BYTE_W - 1;

   generate
      if (MODE_BIT < 0 || MODE_BIT >= BYTE_W) begin : g_bad_mode
         $error("disp_start_addr: MODE_BIT out of range");
      end
   endgenerate

   dsa_shadow_t       shadow;
   logic              commit;
   logic              vs_rise;
   logic              xfer;
   logic [ADDR_W-1:0] active;

   dsa_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(vsync_in), .rise(vs_rise));

   assign xfer = vs_rise & commit;

   dsa_regfile #(
      .IDX_HI(IDX_HI), .IDX_LO(IDX_LO), .IDX_EXT(IDX_EXT),
      .IDX_EXTHI(IDX_EXTHI), .IDX_CTRL(IDX_CTRL), .ARM_BIT(ARM_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .idx(cfg_idx),
      .wdata(cfg_wdata), .xfer(xfer), .shadow(shadow),
      .commit(commit), .rdata(cfg_rdata));

   dsa_active u_active (
      .clk(clk), .rst_n(rst_n), .xfer(xfer), .shadow(shadow),
      .active(active));

   assign start_addr     = shadow.ctrl[MODE_BIT] ? active
                                                 : dsa_legacy_addr(shadow);
   assign commit_pending = commit;

   // R7
   no_xfer_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vs_rise && !commit_pending) |=> $stable(active));
endmodule

// File: tb/disp_start_addr_test.sv
module disp_start_addr_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [7:0]  cfg_idx = 8'h00;
   logic [7:0]  cfg_wdata = 8'h00;
   logic [7:0]  cfg_rdata;
   logic        vsync_in = 1'b0;
   logic [31:0] start_addr;
   logic        commit_pending;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;

   disp_start_addr uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .vsync_in(vsync_in),
      .start_addr(start_addr), .commit_pending(commit_pending));

   function automatic logic [31:0] ext_model(logic [7:0] xh, logic [7:0] x,
                                              logic [7:0] h, logic [7:0] l);
      return {xh, x[5:0], h, l, 2'b00};
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] i, logic [7:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_idx = i; cfg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic rd_check(string req, logic [7:0] i, logic [7:0] exp);
      @(negedge clk);
      cfg_idx = i;
      #1;
      check(req, {24'h0, cfg_rdata}, {24'h0, exp});
   endtask

   task automatic vs_pulse();
      @(negedge clk); vsync_in = 1'b1;
      repeat (4) @(posedge clk);
      @(negedge clk); vsync_in = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      rd_check("R1 hi", 8'h0C, 8'h00);
      rd_check("R1 ext", 8'h20, 8'h00);
      rd_check("R1 ctrl", 8'h30, 8'h00);
      check("R1 addr", start_addr, 32'h0);
      check("R1 commit", {31'h0, commit_pending}, 32'h0);
   endtask

   task automatic t_regs_legacy();
      wr(8'h0C, 8'hA5);
      check("R3 hi follows", start_addr, 32'h0000_A500);
      wr(8'h0D, 8'h3C);
      check("R3 lo follows", start_addr, 32'h0000_A53C);
      wr(8'h21, 8'h12);
      wr(8'h20, 8'h3F);
      rd_check("R2 read hi", 8'h0C, 8'hA5);
      rd_check("R2 read lo", 8'h0D, 8'h3C);
      rd_check("R2 read exthi", 8'h21, 8'h12);
      rd_check("R2 read ext", 8'h20, 8'h3F);
      rd_check("R2 unused idx", 8'h55, 8'h00);
      check("R3 legacy ignores ext regs", start_addr, 32'h0000_A53C);
   endtask

   task automatic t_ext_commit();
      wr(8'h30, 8'h01);
      check("R5 ext before xfer", start_addr, 32'h0);
      wr(8'h0C, 8'h81);
      check("R5 write no effect", start_addr, 32'h0);
      vs_pulse();
      check("R7 unarmed vsync", start_addr, 32'h0);
      wr(8'h20, 8'hBF);
      check("R6 armed", {31'h0, commit_pending}, 32'h1);
      rd_check("R6 read arm bit", 8'h20, 8'hBF);
      wr(8'h20, 8'h3F);
      check("R6 zero no clear", {31'h0, commit_pending}, 32'h1);
      check("R5 armed no xfer yet", start_addr, 32'h0);
      vs_pulse();
      check("R4 assembled", start_addr, ext_model(8'h12, 8'h3F, 8'h81, 8'h3C));
      check("R8 cleared", {31'h0, commit_pending}, 32'h0);
      rd_check("R8 read cleared", 8'h20, 8'h3F);
   endtask

   task automatic t_timing_and_race();
      logic [31:0] first;
      wr(8'h21, 8'hC3);
      wr(8'h0D, 8'h01);
      wr(8'h20, 8'h80);
      first = ext_model(8'hC3, 8'h80, 8'h81, 8'h01);
      @(negedge clk); vsync_in = 1'b1;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      check("R7 not before sync", start_addr, ext_model(8'h12, 8'h3F, 8'h81, 8'h3C));
      cfg_wr = 1'b1; cfg_idx = 8'h20; cfg_wdata = 8'h80;
      @(posedge clk);
      @(negedge clk);
      cfg_wr = 1'b0;
      check("R7 xfer third edge", start_addr, first);
      check("R9 set wins", {31'h0, commit_pending}, 32'h1);
      wr(8'h0D, 8'h02);
      repeat (6) @(posedge clk);
      @(negedge clk);
      check("R8 held high no retransfer", start_addr, first);
      check("R9 still armed", {31'h0, commit_pending}, 32'h1);
      vsync_in = 1'b0;
      repeat (4) @(posedge clk);
      vs_pulse();
      check("R9 next frame xfer", start_addr, ext_model(8'hC3, 8'h80, 8'h81, 8'h02));
      check("R8 cleared again", {31'h0, commit_pending}, 32'h0);
      wr(8'h30, 8'h00);
      check("R3 back to legacy", start_addr, 32'h0000_8102);
   endtask

   initial begin
      fork
         begin
            repeat (4) @(posedge clk);
            @(negedge clk); rst_n = 1'b1;
            t_reset();
            t_regs_legacy();
            t_ext_commit();
            t_timing_and_race();
         end
         begin
            repeat (20000) @(posedge clk);
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule